// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the synchronized clock and data lines of a two-wire SMBus port and raises flags when the bus stays in one state for too long. It measures four intervals against thresholds that software writes as clock-cycle counts. The first is the clock held low. The second is both lines held high, which means the bus is idle. The third is data held low while the clock is high. The fourth is the total time, within one byte, that this module has itself held the clock low while it is master.

The monitor finds START, STOP and the acknowledge slot on its own and keeps a bus-busy indication. When the clock-low timeout occurs, the action depends on the role input. A master gets a held request to send a STOP. A slave gets a one-cycle request to reset its receive logic so that it can accept a fresh START. Every flag is sticky. Software clears a flag by writing a one to it. A single interrupt request combines the flags that software has enabled.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset, flags, idle_mid, busy, irq, stop_req and slave_reset are all 0.
- R2: Flag bit 0 (clock-low) sets after scl has been sampled low on thr_low consecutive clock edges. It is still 0 after thr_low-1 such edges. Any edge that samples scl high restarts the count.
- R3: In master role (is_master=1), stop_req rises in the same cycle as the clock-low flag. It stays high until a STOP (sda rising while scl is high) is seen on the bus.
- R4: In slave role (is_master=0), a clock-low timeout gives a one-cycle slave_reset pulse in the same cycle as the flag, and stop_req stays 0.
- R5: Flag bit 1 (bus idle) sets after scl and sda have both been sampled high on thr_high consecutive edges. busy clears in that same cycle.
- R6: busy sets on a START (sda falling while scl is high) and clears on a STOP.
- R7: If the idle flag sets while busy is high, which means a START was seen with no STOP after it, idle_mid sets. An idle timeout after a STOP leaves idle_mid at 0. flag_clr bit 1 also clears idle_mid.
- R8: Flag bit 2 (data stuck) sets after sda low with scl high has been sampled on thr_sda consecutive edges.
- R9: Flag bit 3 (stretch budget) sets when the edges sampled with is_master=1, self_stretch=1 and scl=0 total thr_mext within one byte, even when they fall in separate intervals. Flag bit 0 sets together with it. Edges in slave role or without self_stretch do not count.
- R10: The stretch total restarts at a byte boundary: the ninth scl rising edge after START, a START, or a STOP.
- R11: Each flag stays set until a flag_clr pulse on its bit. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R12: irq is high exactly when some flag bit and the same irq_en bit are both high. It changes in the same cycle as the flags.
- R13: A threshold of 0 disables its timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized clock line |
| sda | input | 1 | Synchronized data line |
| is_master | input | 1 | 1 when the module acts as master |
| self_stretch | input | 1 | Master sequencer is holding scl low itself |
| thr_low | input | CW | Clock-low limit in cycles, 0 disables |
| thr_high | input | CW | Both-high (idle) limit in cycles, 0 disables |
| thr_sda | input | CW | Data-low/clock-high limit, 0 disables |
| thr_mext | input | CW | Per-byte stretch budget, 0 disables |
| irq_en | input | 4 | Interrupt enable per flag |
| flag_clr | input | 4 | Write-one-to-clear pulse per flag |
| flags | output | 4 | Sticky flags: 0 low, 1 idle, 2 data stuck, 3 stretch |
| idle_mid | output | 1 | Idle timeout reached with a transfer open |
| busy | output | 1 | Bus busy |
| irq | output | 1 | Combined interrupt request |
| stop_req | output | 1 | Request to the master sequencer to send STOP |
| slave_reset | output | 1 | One-cycle reset request to the slave logic |

## Verification
The line inputs are registered once for edge detection, and each flag has one output register. A condition applied before edge k therefore shows on the flags right after edge k+N-1, where N is the threshold. slave_reset, stop_req, irq, busy and idle_mid change on that same edge. The bench drives every input on the falling clock edge and advances whole cycles. It reads each output at the falling edge one cycle before its due edge, to confirm the output is still clear, and again on the due edge, to confirm it has changed. The threshold sweeps repeat this timing for every small threshold value.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  localparam int NF     = 4;
  localparam int F_LOW  = 0;
  localparam int F_IDLE = 1;
  localparam int F_SDA  = 2;
  localparam int F_MEXT = 3;
  localparam int BYTE_BITS = 9;
endpackage

// File: rtl/smbto_counter.sv
module smbto_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] thr,
  input  logic          inc,
  input  logic          clr,
  output logic          hit
);
  logic [CW-1:0] cnt;
  logic          armed;

  assign armed = (thr != '0);
  assign hit   = armed && inc && !clr && (cnt == thr - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)                             cnt <= '0;
    else if (clr)                        cnt <= '0;
    else if (inc && armed && cnt < thr)  cnt <= cnt + 1'b1;
  end

  // R2: count never grows once it has reached the threshold
  p_hold_at_limit_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && cnt >= thr) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/smbto_bus_events.sv
module smbto_bus_events #(
  parameter int BITS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  input  logic busy,
  input  logic resync,
  output logic start_ev,
  output logic stop_ev,
  output logic byte_end
);
  localparam int BW = $clog2(BITS + 1);

  logic          scl_q, sda_q, rise;
  logic [BW-1:0] bitcnt;

  assign rise     = scl && !scl_q;
  assign start_ev = scl && scl_q && sda_q && !sda;
  assign stop_ev  = scl && scl_q && !sda_q && sda;
  assign byte_end = rise && busy && (bitcnt == BW'(BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      bitcnt <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_ev || stop_ev || resync) bitcnt <= '0;
      else if (byte_end)                 bitcnt <= '0;
      else if (rise && busy)             bitcnt <= bitcnt + 1'b1;
    end
  end

  // R10: bit position stays within one byte plus acknowledge
  p_bitcnt_range_r10: assert property (@(posedge clk) disable iff (rst)
    bitcnt < BW'(BITS));
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon
  import smbto_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          sda,
  input  logic          is_master,
  input  logic          self_stretch,
  input  logic [CW-1:0] thr_low,
  input  logic [CW-1:0] thr_high,
  input  logic [CW-1:0] thr_sda,
  input  logic [CW-1:0] thr_mext,
  input  logic [NF-1:0] irq_en,
  input  logic [NF-1:0] flag_clr,
  output logic [NF-1:0] flags,
  output logic          idle_mid,
  output logic          busy,
  output logic          irq,
  output logic          stop_req,
  output logic          slave_reset
);
  logic start_ev, stop_ev, byte_end;
  logic hit_low, hit_high, hit_sda, hit_mext;
  logic c_low, c_high, c_sda, c_mext;
  logic [NF-1:0] set_v, flags_d;

  assign c_low  = !scl;
  assign c_high = scl && sda;
  assign c_sda  = scl && !sda;
  assign c_mext = is_master && self_stretch && !scl;

  smbto_bus_events #(.BITS(BYTE_BITS)) u_events (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda), .busy(busy),
    .resync(slave_reset), .start_ev(start_ev), .stop_ev(stop_ev),
    .byte_end(byte_end)
  );

  smbto_counter #(.CW(CW)) u_cnt_low (
    .clk(clk), .rst(rst), .thr(thr_low), .inc(c_low), .clr(!c_low), .hit(hit_low));
  smbto_counter #(.CW(CW)) u_cnt_high (
    .clk(clk), .rst(rst), .thr(thr_high), .inc(c_high), .clr(!c_high), .hit(hit_high));
  smbto_counter #(.CW(CW)) u_cnt_sda (
    .clk(clk), .rst(rst), .thr(thr_sda), .inc(c_sda), .clr(!c_sda), .hit(hit_sda));
  smbto_counter #(.CW(CW)) u_cnt_mext (
    .clk(clk), .rst(rst), .thr(thr_mext), .inc(c_mext),
    .clr(byte_end || start_ev || stop_ev), .hit(hit_mext));

  always_comb begin
    set_v         = '0;
    set_v[F_LOW]  = hit_low || hit_mext;
    set_v[F_IDLE] = hit_high;
    set_v[F_SDA]  = hit_sda;
    set_v[F_MEXT] = hit_mext;
    flags_d       = (flags & ~flag_clr) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags       <= '0;
      irq         <= 1'b0;
      busy        <= 1'b0;
      idle_mid    <= 1'b0;
      stop_req    <= 1'b0;
      slave_reset <= 1'b0;
    end else begin
      flags       <= flags_d;
      irq         <= |(flags_d & irq_en);
      slave_reset <= hit_low && !is_master;
      if (hit_high)      busy <= 1'b0;
      else if (start_ev) busy <= 1'b1;
      else if (stop_ev)  busy <= 1'b0;
      if (hit_high && busy)     idle_mid <= 1'b1;
      else if (flag_clr[F_IDLE]) idle_mid <= 1'b0;
      if (hit_low && is_master) stop_req <= 1'b1;
      else if (stop_ev)         stop_req <= 1'b0;
    end
  end

  // R11: a set flag stays set without a clear pulse
  for (genvar i = 0; i < NF; i++) begin : g_sticky
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !flag_clr[i]) |=> flags[i]);
  end

  // R6: a START marks the bus busy
  p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> busy);

  // R9: stretch budget overrun also raises the clock-low flag
  p_mext_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_MEXT]) |-> flags[F_LOW]);

  // R12: interrupt tracks enabled flags
  p_irq_r12: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & $past(irq_en)));

  // R4: slave reset request is a single-cycle pulse
  p_slave_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    slave_reset |=> !slave_reset);

  // R3: stop requests come only from the master role
  p_stop_master_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_req) |-> $past(is_master));
endmodule

// File: tb/test_smbus_timeout_mon.sv
`timescale 1ns/1ps
module test_smbus_timeout_mon;
  localparam int CW = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic scl, sda, is_master, self_stretch;
  logic [CW-1:0] thr_low, thr_high, thr_sda, thr_mext;
  logic [3:0] irq_en, flag_clr, flags;
  logic idle_mid, busy, irq, stop_req, slave_reset;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smbus_timeout_mon #(.CW(CW)) i_smbus_timeout_mon (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda), .is_master(is_master),
    .self_stretch(self_stretch), .thr_low(thr_low), .thr_high(thr_high),
    .thr_sda(thr_sda), .thr_mext(thr_mext), .irq_en(irq_en), .flag_clr(flag_clr),
    .flags(flags), .idle_mid(idle_mid), .busy(busy), .irq(irq),
    .stop_req(stop_req), .slave_reset(slave_reset));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic restart();
    scl = 1; sda = 1; is_master = 0; self_stretch = 0;
    thr_low = 200; thr_high = 200; thr_sda = 200; thr_mext = 200;
    irq_en = 0; flag_clr = 0;
    rst = 1; tick(2); rst = 0;
  endtask

  initial begin
    @(negedge clk);
    restart();
    // R1 reset state
    check({flags, idle_mid, busy, irq, stop_req, slave_reset}, 0, "R1 reset outputs");

    // R2 sweep clock-low threshold
    for (int t = 1; t <= 5; t++) begin
      restart(); thr_low = t[CW-1:0];
      scl = 0; sda = 0;
      if (t > 1) begin tick(t - 1); check(flags[0], 0, "R2 before limit"); tick(1); end
      else tick(1);
      check(flags[0], 1, "R2 at limit");
    end
    // R2 restart on high sample
    restart(); thr_low = 4; scl = 0; tick(3); scl = 1; tick(1); scl = 0; tick(3);
    check(flags[0], 0, "R2 restart after high");
    tick(1); check(flags[0], 1, "R2 after restart");

    // R3 master stop request
    restart(); is_master = 1; thr_low = 3; scl = 0; tick(2);
    check(stop_req, 0, "R3 early"); tick(1);
    check(stop_req, 1, "R3 raised"); check(flags[0], 1, "R3 flag");
    scl = 1; tick(2); check(stop_req, 1, "R3 held");
    sda = 0; tick(1); sda = 1; tick(1); check(stop_req, 0, "R3 cleared by STOP");

    // R4 slave reset pulse
    restart(); thr_low = 3; scl = 0; tick(2);
    check(slave_reset, 0, "R4 early"); tick(1);
    check(slave_reset, 1, "R4 pulse"); check(stop_req, 0, "R4 no stop req");
    tick(1); check(slave_reset, 0, "R4 one cycle");

    // R5 idle
    restart(); thr_high = 4; tick(3); check(flags[1], 0, "R5 before limit");
    tick(1); check(flags[1], 1, "R5 idle flag");

    // R6 busy
    restart(); sda = 0; tick(1); check(busy, 1, "R6 START sets busy");
    sda = 1; tick(1); check(busy, 0, "R6 STOP clears busy");

    // R7 idle while busy
    restart(); sda = 0; tick(1); scl = 0; tick(1); sda = 1; tick(1);
    thr_high = 4; scl = 1; tick(3); check(busy, 1, "R7 busy before idle");
    tick(1); check(flags[1], 1, "R7 idle flag"); check(idle_mid, 1, "R7 idle_mid set");
    check(busy, 0, "R5 busy cleared by idle");
    flag_clr = 4'b0010; tick(1); flag_clr = 0;
    check(idle_mid, 0, "R7 idle_mid cleared");
    restart(); sda = 0; tick(1); sda = 1; thr_high = 3; tick(5);
    check(flags[1], 1, "R7 idle after STOP"); check(idle_mid, 0, "R7 no idle_mid after STOP");

    // R8 sweep data stuck
    for (int t = 1; t <= 4; t++) begin
      restart(); thr_sda = t[CW-1:0]; sda = 0;
      if (t > 1) begin tick(t - 1); check(flags[2], 0, "R8 before limit"); tick(1); end
      else tick(1);
      check(flags[2], 1, "R8 at limit");
    end

    // R9 cumulative stretch
    restart(); is_master = 1; thr_mext = 5;
    scl = 0; self_stretch = 1; tick(3);
    scl = 1; self_stretch = 0; tick(1);
    scl = 0; tick(4); scl = 1; tick(1);
    scl = 0; self_stretch = 1; tick(1); check(flags[3], 0, "R9 below budget");
    tick(1); check(flags[3], 1, "R9 budget reached"); check(flags[0], 1, "R9 low flag too");
    restart(); thr_mext = 3; scl = 0; self_stretch = 1; tick(10);
    check(flags[3], 0, "R9 slave ignored");

    // R10 byte boundary via ninth rise, then STOP+START
    restart(); is_master = 1; thr_mext = 6; sda = 0; tick(1);
    scl = 0; self_stretch = 1; tick(4);
    scl = 1; self_stretch = 0; tick(1);
    for (int k = 0; k < 8; k++) begin scl = 0; tick(1); scl = 1; tick(1); end
    scl = 0; self_stretch = 1; tick(5); check(flags[3], 0, "R10 ninth rise clears");
    scl = 1; self_stretch = 0; tick(1); sda = 1; tick(1); sda = 0; tick(1);
    scl = 0; self_stretch = 1; tick(5); check(flags[3], 0, "R10 STOP/START clears");
    tick(1); check(flags[3], 1, "R10 budget after boundary");

    // R11 clear and set-wins
    restart(); thr_low = 3; scl = 0; tick(3); scl = 1; tick(1);
    flag_clr = 4'b0001; tick(1); flag_clr = 0; check(flags[0], 0, "R11 W1C");
    restart(); thr_low = 3; scl = 0; tick(2); flag_clr = 4'b0001; tick(1); flag_clr = 0;
    check(flags[0], 1, "R11 set wins");

    // R12 interrupt masking
    restart(); thr_sda = 2; irq_en = 4'b0001; sda = 0; tick(2);
    check(flags[2], 1, "R12 flag"); check(irq, 0, "R12 masked");
    irq_en = 4'b0100; tick(1); check(irq, 1, "R12 enabled");
    flag_clr = 4'b0100; tick(1); flag_clr = 0; check(irq, 0, "R12 cleared with flag");

    // R13 zero threshold
    restart(); thr_low = 0; scl = 0; tick(20);
    check(flags[0], 0, "R13 disabled"); check(slave_reset, 0, "R13 no reset req");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule